// File: doc/BRIEF.md
# Input Capture Transition Counter

This block is one timer channel that watches a single input pin for edges. Each edge that matches the programmed pin action is stamped with the value of one of two free-running 16-bit time bases. The channel keeps a running count of these edges and the time of the most recent one. When the count reaches a programmed maximum, it also records that edge's time as the final time and raises an interrupt status bit. The status bit reaches the interrupt output only while the interrupt enable is set.

The host programs the channel through a small write-only register port and reads the results directly on output ports. The host starts the channel by writing the initialize code (01) into the service request field. The channel clears its count and timestamps, writes 00 back to that field and starts counting. A sequence bit picks the mode at the final edge. In single-shot mode the channel stops there. In continual mode it clears the count and keeps going.

The control state machine has four states:
- `ST_IDLE`: the reset state, waiting for a service request.
- `ST_INIT`: one cycle that clears the results and completes the service request.
- `ST_COUNT`: capturing edges.
- `ST_DONE`: single shot finished; no further capture.

Its transitions are:
- idle→init on a pending request.
- init→count, always, after its one cycle.
- count→done on the final edge in single-shot mode.
- count→init on a new request.
- done→init on a new request.

Top module: `edge_capture_counter`

Register map. Writes take `cfg_addr` and `cfg_wdata` while `cfg_we` is high.

| Address | Bits | Field |
|---|---|---|
| 0 | [3:0] | time base select |
| 0 | [6:4] | pin action |
| 0 | [8:7] | pin state |
| 1 | [15:0] | maximum count |
| 2 | [0] | continual mode |
| 2 | [1] | interrupt enable |
| 3 | [1:0] | service request code |
| 3 | [2] | clear interrupt status (write 1) |

Reset values: time base select 0000, pin action 000, pin state 11, maximum count 0, continual mode 0, interrupt enable 0.

## Requirements
- R1: Time base select pattern 001x (bits [3:1] = 001) timestamps edges with `tb_b`. Every other value, including 000x, uses `tb_a`.
- R2: Pin action encodings are 001 rising edge, 010 falling edge, 011 either edge and 000 no detection. With 000, pin edges leave the count and times unchanged.
- R3: A control write whose pin action has bit 2 set (1xx) leaves the stored pin action unchanged. The other control fields in that write still update.
- R4: Pin state 01 drives `pin_oe`=1 and `pin_drive`=1. Pin state 10 drives `pin_oe`=1 and `pin_drive`=0. Pin state 11 (and 00) drives `pin_oe`=0.
- R5: While counting, each qualifying edge increments `trans_count` by one and loads the selected time base value into `last_time`.
- R6: When an edge makes the count equal a nonzero maximum count, that edge's time goes to `final_time` and `irq_status` is set. A maximum count of 0 never sets the status.
- R7: `irq_out` equals `irq_status` AND the interrupt enable bit.
- R8: In single-shot mode (continual bit 0), the channel stops after the final edge. Later edges change neither `trans_count` nor the times.
- R9: In continual mode (continual bit 1), the final edge clears `trans_count` to 0 and counting continues.
- R10: Writing request code 01 starts the channel. It clears the count and both times, and `hsr_state` reads 01 until the channel writes 00 back two cycles later. Other codes are ignored.
- R11: Writing 1 to address 3 bit 2 clears `irq_status`. A status set in the same cycle wins over the clear.
- R12: The pin passes through a two-flop synchronizer, and at most one edge is counted per clock. An edge's result is visible at the outputs within three rising clock edges of the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| tb_a | input | 16 | First free-running time base |
| tb_b | input | 16 | Second free-running time base |
| pin_in | input | 1 | Asynchronous channel pin |
| pin_oe | output | 1 | Pin force enable |
| pin_drive | output | 1 | Forced pin level |
| trans_count | output | 16 | Transitions captured so far |
| last_time | output | 16 | Time of the most recent captured edge |
| final_time | output | 16 | Time of the edge that reached the maximum count |
| hsr_state | output | 2 | Service request field (01 pending, 00 complete) |
| irq_status | output | 1 | Interrupt status bit |
| irq_out | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with its default parameters:
- 16-bit time bases, count and data width.
- Two synchronizer stages.

Small maximum counts (0, 1, 2 and 3) bring every compare-and-final path within a few edges. Both single-shot stopping and continual wrap are therefore reached many times. The time bases are held at random values around each pin change, so a swapped time base select or a missing stamp shows directly in `last_time` and `final_time`. A random phase mixes pin actions, time base selects and modes against a bench model.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_COUNT,
        ST_DONE
    } ecc_state_e;

    localparam logic [2:0] PACT_NONE   = 3'b000;
    localparam logic [2:0] PACT_RISE   = 3'b001;
    localparam logic [2:0] PACT_FALL   = 3'b010;
    localparam logic [2:0] PACT_EITHER = 3'b011;

    localparam logic [1:0] PST_HIGH = 2'b01;
    localparam logic [1:0] PST_LOW  = 2'b10;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MAX  = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;
    localparam logic [1:0] ADDR_SVC  = 2'd3;

    localparam logic [1:0] SVC_INIT = 2'b01;

endpackage

// File: rtl/ecc_edge_detect.sv
module ecc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [2:0] pin_action,
    output logic       edge_hit
);
    import ecc_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;
    logic                   rise;
    logic                   fall;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;

    always_comb begin
        unique case (pin_action)
            PACT_RISE:   edge_hit = rise;
            PACT_FALL:   edge_hit = fall;
            PACT_EITHER: edge_hit = rise | fall;
            default:     edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs #(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          svc_done,
    output logic [3:0]    tbs,
    output logic [2:0]    pin_action,
    output logic [1:0]    pin_state,
    output logic [CW-1:0] max_count,
    output logic          continual,
    output logic          irq_en,
    output logic [1:0]    hsr,
    output logic          stat_clr
);
    import ecc_pkg::*;

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbs        <= 4'b0000;
            pin_action <= PACT_NONE;
            pin_state  <= 2'b11;
            max_count  <= '0;
            continual  <= 1'b0;
            irq_en     <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_CTRL: begin
                    tbs       <= cfg_wdata[3:0];
                    pin_state <= cfg_wdata[8:7];
                    if (!cfg_wdata[6]) pin_action <= cfg_wdata[6:4];
                end
                ADDR_MAX:  max_count <= cfg_wdata[CW-1:0];
                ADDR_MODE: begin
                    continual <= cfg_wdata[0];
                    irq_en    <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hsr <= 2'b00;
        else if (cfg_we && cfg_addr == ADDR_SVC && cfg_wdata[1:0] == SVC_INIT)
            hsr <= SVC_INIT;
        else if (svc_done)
            hsr <= 2'b00;
    end

    assign stat_clr = cfg_we && (cfg_addr == ADDR_SVC) && cfg_wdata[2];
endmodule

// File: rtl/ecc_capture_core.sv
module ecc_capture_core #(
    parameter int TW = 16,
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               edge_hit,
    input  logic [TW-1:0]      tstamp,
    input  logic [CW-1:0]      max_count,
    input  logic               continual,
    input  logic               svc_pending,
    input  logic               stat_clr,
    output logic               svc_done,
    output ecc_pkg::ecc_state_e state,
    output logic [CW-1:0]      trans_count,
    output logic [TW-1:0]      last_time,
    output logic [TW-1:0]      final_time,
    output logic               irq_status
);
    import ecc_pkg::*;

    ecc_state_e    state_nx;
    logic [CW-1:0] cnt_inc;
    logic          take;
    logic          reach;

    assign cnt_inc = trans_count + 1'b1;
    assign take    = (state == ST_COUNT) && edge_hit;
    assign reach   = take && (max_count != '0) && (cnt_inc == max_count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        svc_done = 1'b0;
        unique case (state)
            ST_IDLE:  if (svc_pending) state_nx = ST_INIT;
            ST_INIT: begin
                svc_done = 1'b1;
                state_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (svc_pending)            state_nx = ST_INIT;
                else if (reach && !continual) state_nx = ST_DONE;
            end
            ST_DONE:  if (svc_pending) state_nx = ST_INIT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trans_count <= '0;
            last_time   <= '0;
            final_time  <= '0;
        end else if (state == ST_INIT) begin
            trans_count <= '0;
            last_time   <= '0;
            final_time  <= '0;
        end else if (take) begin
            last_time <= tstamp;
            if (reach) begin
                final_time  <= tstamp;
                trans_count <= continual ? '0 : cnt_inc;
            end else begin
                trans_count <= cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_status <= 1'b0;
        else if (reach)    irq_status <= 1'b1;
        else if (stat_clr) irq_status <= 1'b0;
    end
endmodule

// File: rtl/edge_capture_counter.sv
module edge_capture_counter #(
    parameter int TW          = 16,
    parameter int CW          = 16,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [TW-1:0] tb_a,
    input  logic [TW-1:0] tb_b,
    input  logic          pin_in,
    output logic          pin_oe,
    output logic          pin_drive,
    output logic [CW-1:0] trans_count,
    output logic [TW-1:0] last_time,
    output logic [TW-1:0] final_time,
    output logic [1:0]    hsr_state,
    output logic          irq_status,
    output logic          irq_out
);
    import ecc_pkg::*;

    logic [3:0]    tbs;
    logic [2:0]    pin_action;
    logic [1:0]    pin_state;
    logic [CW-1:0] max_count;
    logic          continual;
    logic          irq_en;
    logic          stat_clr;
    logic          svc_done;
    logic          edge_hit;
    logic [TW-1:0] tstamp;
    ecc_state_e    state_w;
    logic          unused_tbs;

    assign unused_tbs = tbs[0];

    ecc_cfg_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .svc_done(svc_done),
        .tbs(tbs), .pin_action(pin_action), .pin_state(pin_state),
        .max_count(max_count), .continual(continual), .irq_en(irq_en),
        .hsr(hsr_state), .stat_clr(stat_clr)
    );

    ecc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_action(pin_action), .edge_hit(edge_hit)
    );

    assign tstamp = (tbs[3:1] == 3'b001) ? tb_b : tb_a;

    ecc_capture_core #(.TW(TW), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n),
        .edge_hit(edge_hit), .tstamp(tstamp),
        .max_count(max_count), .continual(continual),
        .svc_pending(hsr_state == SVC_INIT), .stat_clr(stat_clr),
        .svc_done(svc_done), .state(state_w),
        .trans_count(trans_count), .last_time(last_time),
        .final_time(final_time), .irq_status(irq_status)
    );

    always_comb begin
        pin_oe    = (pin_state == PST_HIGH) || (pin_state == PST_LOW);
        pin_drive = (pin_state == PST_HIGH);
    end

    assign irq_out = irq_status & irq_en;
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker #(
    parameter int TW = 16,
    parameter int CW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [1:0]         cfg_addr,
    input ecc_pkg::ecc_state_e state,
    input logic [1:0]         pin_state,
    input logic               pin_oe,
    input logic [CW-1:0]      trans_count,
    input logic [TW-1:0]      last_time,
    input logic [TW-1:0]      final_time,
    input logic [1:0]         hsr_state,
    input logic               irq_status,
    input logic               irq_out,
    input logic               irq_en
);
    import ecc_pkg::*;

    // R6: the final time equals the last time on the edge that sets status
    a_r6_final_matches_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status) |-> final_time == last_time);

    // R7: no request reaches the host without status and enable
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_status && irq_en));

    // R10: the service field returns to 00 after the init cycle
    a_r10_svc_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT && !(cfg_we && cfg_addr == ADDR_SVC)) |=> hsr_state == 2'b00);

    // R12: the count moves by at most one per clock or clears
    a_r12_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_count == $past(trans_count)) || (trans_count == $past(trans_count) + 1'b1)
        || (trans_count == '0));

    // R8: a finished single shot holds its results
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_DONE) |-> ($stable(trans_count) && $stable(last_time)));

    // R4: an unforced input pin is never driven
    a_r4_no_force: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_state == 2'b11) |-> !pin_oe);
endmodule

bind edge_capture_counter ecc_checker #(.TW(TW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .state(state_w), .pin_state(pin_state), .pin_oe(pin_oe),
    .trans_count(trans_count), .last_time(last_time), .final_time(final_time),
    .hsr_state(hsr_state), .irq_status(irq_status), .irq_out(irq_out),
    .irq_en(irq_en)
);

// File: tb/edge_capture_counter_tb_top.sv
module edge_capture_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] tb_a = '0;
    logic [15:0] tb_b = '0;
    logic        pin_in = 1'b0;
    logic        pin_oe, pin_drive, irq_status, irq_out;
    logic [15:0] trans_count, last_time, final_time;
    logic [1:0]  hsr_state;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    logic [2:0]  m_pac = 3'b000;
    logic [3:0]  m_tbs = 4'b0000;
    logic [15:0] m_max = '0;
    bit          m_cont = 0, m_ien = 0, m_run = 0, m_stat = 0, m_pin = 0;
    logic [15:0] m_cnt = '0, m_last = '0, m_final = '0;

    always #10 clk = ~clk;

    edge_capture_counter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tb_a(tb_a), .tb_b(tb_b), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_drive(pin_drive), .trans_count(trans_count),
        .last_time(last_time), .final_time(final_time), .hsr_state(hsr_state),
        .irq_status(irq_status), .irq_out(irq_out)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit qualifies(input logic [2:0] pac, input bit old_l, input bit new_l);
        case (pac)
            3'b001:  return !old_l && new_l;
            3'b010:  return old_l && !new_l;
            3'b011:  return old_l != new_l;
            default: return 0;
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            2'd0: begin m_tbs = d[3:0]; if (!d[6]) m_pac = d[6:4]; end
            2'd1: m_max = d;
            2'd2: begin m_cont = d[0]; m_ien = d[1]; end
            default: begin
                if (d[2]) m_stat = 0;
                if (d[1:0] == 2'b01) begin
                    m_cnt = 0; m_last = 0; m_final = 0; m_run = 1;
                end
            end
        endcase
    endtask

    task automatic ctrl(input logic [3:0] tbs, input logic [2:0] pac, input logic [1:0] psc);
        wr(2'd0, {7'd0, psc, pac, tbs});
    endtask

    task automatic start();
        wr(2'd3, 16'h0001);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        chk({req, " count"}, trans_count, m_cnt);
        chk({req, " last"}, last_time, m_last);
        chk({req, " final"}, final_time, m_final);
        chk({req, " status"}, {15'd0, irq_status}, {15'd0, m_stat});
        chk({req, " irq"}, {15'd0, irq_out}, {15'd0, m_stat & m_ien});
    endtask

    task automatic pin_to(input bit lvl);
        logic [15:0] t;
        bit q;
        @(negedge clk);
        tb_a = 16'($urandom);
        tb_b = 16'($urandom);
        pin_in = lvl;
        q = qualifies(m_pac, m_pin, lvl);
        m_pin = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (m_run && q) begin
            t = (m_tbs[3:1] == 3'b001) ? tb_b : tb_a;
            m_last = t;
            if (m_max != 0 && m_cnt + 16'd1 == m_max) begin
                m_final = t; m_stat = 1;
                if (m_cont) m_cnt = 0;
                else begin m_cnt = m_cnt + 1; m_run = 0; end
            end else m_cnt = m_cnt + 1;
        end
    endtask

    task automatic pulse();
        pin_to(1'b1);
        pin_to(1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check_all("R10 reset");
        chk("R10 reset hsr", {14'd0, hsr_state}, 16'd0);
        chk("R4 reset oe", {15'd0, pin_oe}, 16'd0);

        // R10: service request start and completion
        ctrl(4'b0000, 3'b001, 2'b11);
        wr(2'd1, 16'd3);
        wr(2'd2, 16'h0002);
        wr(2'd3, 16'h0002);          // R10 other code ignored
        chk("R10 other code ignored", {14'd0, hsr_state}, 16'd0);
        pulse();
        check_all("R10 idle no capture");
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'h0001;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R10 pending", {14'd0, hsr_state}, 16'd1);
        repeat (2) @(negedge clk);
        chk("R10 complete", {14'd0, hsr_state}, 16'd0);
        m_cnt = 0; m_last = 0; m_final = 0; m_run = 1;

        // R5 R6 R8 single shot rising edges on base A
        pulse(); check_all("R5 first rise");
        pulse(); check_all("R5 second rise");
        pulse(); check_all("R6 final reached");
        chk("R6 status set", {15'd0, irq_status}, 16'd1);
        pulse(); pulse(); check_all("R8 single shot stopped");
        chk("R8 count held", trans_count, 16'd3);

        // R11 clear status, R7 enable gating
        wr(2'd3, 16'h0004);
        check_all("R11 status clear");
        wr(2'd2, 16'h0000);
        start();
        wr(2'd1, 16'd1);
        pulse(); check_all("R7 status without enable");
        chk("R7 irq gated low", {15'd0, irq_out}, 16'd0);

        // R1 R2 R9 continual falling edges on base B
        wr(2'd3, 16'h0004);
        ctrl(4'b0011, 3'b010, 2'b11);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'h0003);
        start();
        for (int i = 0; i < 5; i++) begin
            pulse(); check_all("R9 continual fall base B R1");
        end
        chk("R9 count wrapped", trans_count, 16'd1);

        // R2 either edge, R1 base A via 000x
        ctrl(4'b0001, 3'b011, 2'b11);
        start();
        pin_to(1'b1); check_all("R2 either rise");
        pin_to(1'b0); check_all("R2 either fall");

        // R3 pin action 1xx keeps either edge
        ctrl(4'b0000, 3'b110, 2'b11);
        pin_to(1'b1); check_all("R3 pac 1xx unchanged");
        chk("R3 count after 1xx", trans_count, 16'd1);

        // R2 no detection
        ctrl(4'b0000, 3'b000, 2'b11);
        pulse(); check_all("R2 none ignored");

        // R6 max zero never reaches
        ctrl(4'b0000, 3'b001, 2'b11);
        wr(2'd3, 16'h0004);
        wr(2'd1, 16'd0);
        start();
        for (int i = 0; i < 4; i++) pulse();
        check_all("R6 max zero");
        chk("R6 max zero status", {15'd0, irq_status}, 16'd0);

        // R12 short pulse of one clock each level still counts once per edge
        wr(2'd1, 16'd100);
        @(negedge clk); pin_in = 1'b1;
        @(negedge clk); pin_in = 1'b0;
        repeat (5) @(negedge clk);
        m_cnt = m_cnt + 1; m_last = tb_a;
        check_all("R12 one-cycle pulse");

        // R4 pin state forcing
        ctrl(4'b0000, 3'b001, 2'b01);
        chk("R4 force high oe", {15'd0, pin_oe}, 16'd1);
        chk("R4 force high lvl", {15'd0, pin_drive}, 16'd1);
        ctrl(4'b0000, 3'b001, 2'b10);
        chk("R4 force low oe", {15'd0, pin_oe}, 16'd1);
        chk("R4 force low lvl", {15'd0, pin_drive}, 16'd0);
        ctrl(4'b0000, 3'b001, 2'b11);
        chk("R4 no force", {15'd0, pin_oe}, 16'd0);

        // random phase
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 7) == 0)
                ctrl(4'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 2'b11);
            if ($urandom_range(0, 11) == 0) begin
                wr(2'd1, 16'($urandom_range(0, 4)));
                wr(2'd2, {14'd0, 1'($urandom), 1'($urandom)});
                wr(2'd3, 16'h0004);
                start();
            end
            pin_to(1'($urandom));
            check_all("R5 R9 random");
        end

        summary();
    end
endmodule